// File: doc/BRIEF.md
# Virtual Interrupt Backlog Resend Unit

A virtual processor is not always running on a hardware thread. When an event queue has backlog enabled and an interrupt for such a processor cannot be delivered, this block sets the bit for that interrupt's priority in a saved pending buffer. The buffer belongs to the processor's record in a small internal table. The interrupt is parked there until the processor is dispatched again.

A hypervisor dispatches a virtual processor by writing a 32-bit context word. The word holds a valid flag and identifies the processor's record. The block always keeps the word as the live context. When the valid flag is set, the block also reads the identified record and takes out any saved pending bits. It clears them in the record and merges them into the live pending buffer, which replays the interrupts that were missed. From the merged buffer the block derives the most favoured pending priority. It raises an interrupt request when that priority beats the current processor priority.

Notify requests and context pushes arrive on separate valid/ready channels. A fixed arbiter serialises them, so that two read-modify-write sequences on the table never overlap.

Top module: `irqbl_resend_top`

## Requirements
- R1: After reset, `pend_buf` is 0, `pend_prio` is 0xFF, `ctx_word` is 0, `irq` is 0, the processor priority is 0 and every record's saved field is empty.
- R2: A notify with `ntf_backlog`=1 and `ntf_fmt1`=0 to a valid record ORs bit (7 - `ntf_prio`) into the record's saved field. The saved field is bits 15..8 of the record word, with bit 15 standing for priority 0. The other bits of the record word are preserved.
- R3: A notify with `ntf_backlog`=1 and `ntf_fmt1`=1 pulses `err_cfg` for one cycle and leaves the record unchanged.
- R4: A notify with `ntf_backlog`=0 changes no record and raises no error.
- R5: In the cycle after a push is accepted, `ctx_word` equals the pushed word. Bit 31 of the word is the valid flag, bits IDX_W-1..0 are the record index, and the next BLK_W bits are the block number.
- R6: A push with the valid flag set moves a non-zero saved field into the live buffer: `pend_buf` becomes `pend_buf` | saved, and the record's field is cleared. A second push to the same record adds nothing.
- R7: A push with the valid flag clear reads no record, so the saved bits stay parked.
- R8: A request whose block number is NUM_BLK or more, or whose index is RECS_PER_BLK or more, pulses `err_id` for one cycle when it would need the table. It changes neither the table nor the live buffer.
- R9: `pend_prio` is the count of leading zeros of `pend_buf`, and 0xFF when `pend_buf` is 0. Both update two cycles after the request is accepted.
- R10: `irq` is 1 exactly when `pend_prio` < processor priority, one cycle after either value changes. The processor priority is loaded through `cppr_we`/`cppr_val`, and its reset value of 0 masks all requests.
- R11: When both channels are valid and the block is idle, the push is accepted and the notify waits. Each request keeps both ready signals low for the two following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ntf_valid | input | 1 | Notify request valid |
| ntf_ready | output | 1 | Notify request accepted when high with valid |
| ntf_blk | input | BLK_W | Notify target block number |
| ntf_idx | input | IDX_W | Notify target record index |
| ntf_prio | input | 3 | Priority of the undelivered interrupt (0 most favoured) |
| ntf_backlog | input | 1 | Backlog enabled on the source queue |
| ntf_fmt1 | input | 1 | Source queue configured as format 1 |
| push_valid | input | 1 | Context push valid |
| push_ready | output | 1 | Context push accepted when high with valid |
| push_word | input | 32 | Context word being pushed |
| cppr_we | input | 1 | Load the processor priority |
| cppr_val | input | 8 | New processor priority |
| ctx_word | output | 32 | Live context word |
| pend_buf | output | 8 | Live pending buffer |
| pend_prio | output | 8 | Most favoured pending priority |
| irq | output | 1 | Interrupt request |
| err_cfg | output | 1 | Pulse: backlog with format 1 |
| err_id | output | 1 | Pulse: record identifier out of range |

## Verification
The case that needs care is a context push and a backlog notify presented in the same idle cycle, both aimed at the same record. The bench raises both valid signals together and checks the ready signals at once: the push must be taken and the notify held off. It then checks that the push found nothing to merge and that the notify's bit stayed parked. A later push must bring that bit into the live buffer with the expected priority, and the request line is then tested on both sides of the priority comparison.

// File: rtl/irqbl_pkg.sv
package irqbl_pkg;

  localparam int CTX_VO_BIT = 31;
  localparam int FLD_LO     = 8;
  localparam int FLD_HI     = 15;
  localparam int NPRIO      = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  // count of leading zeros of an 8-bit buffer, 0xFF when empty
  function automatic logic [7:0] first_pending(input logic [NPRIO-1:0] b);
    logic [7:0] r;
    r = 8'hFF;
    for (int i = 0; i < NPRIO; i++) begin
      if (r == 8'hFF && b[NPRIO-1-i]) r = 8'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/irqbl_arbiter.sv
module irqbl_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic push_valid,
  input  logic ntf_valid,
  output logic push_ready,
  output logic ntf_ready,
  output logic push_fire,
  output logic ntf_fire
);

  // context pushes win over notifies
  assign push_ready = idle;
  assign ntf_ready  = idle && !push_valid;
  assign push_fire  = push_valid && push_ready;
  assign ntf_fire   = ntf_valid && ntf_ready;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    !(push_fire && ntf_fire)); // R11

endmodule

// File: rtl/irqbl_rec_table.sv
module irqbl_rec_table #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] written_q;
  logic [DW-1:0]    rd_q;
  logic             rd_vld_q;

  // plain synchronous RAM, no reset, for block RAM inference
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end

  // per-entry written flags give a reset-clean view without a sweep
  for (genvar g = 0; g < DEPTH; g++) begin : g_wflag
    always_ff @(posedge clk) begin
      if (rst)                               written_q[g] <= 1'b0;
      else if (wr_en && wr_addr == AW'(g))   written_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_vld_q <= 1'b0;
    else if (rd_en) rd_vld_q <= written_q[rd_addr];
  end

  assign rd_data = rd_vld_q ? rd_q : '0;

  AST_NO_RW_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en)); // R6

endmodule

// File: rtl/irqbl_prio_ctx.sv
module irqbl_prio_ctx
  import irqbl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             merge_en,
  input  logic [NPRIO-1:0] merge_bits,
  input  logic             cppr_we,
  input  logic [7:0]       cppr_val,
  output logic [NPRIO-1:0] ipb_q,
  output logic [7:0]       pipr_q,
  output logic             irq_q
);

  logic [7:0]       cppr_q;
  logic [NPRIO-1:0] ipb_next;

  assign ipb_next = ipb_q | merge_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      ipb_q  <= '0;
      pipr_q <= 8'hFF;
      cppr_q <= 8'h00;
      irq_q  <= 1'b0;
    end else begin
      if (merge_en) begin
        ipb_q  <= ipb_next;
        pipr_q <= first_pending(ipb_next);
      end
      if (cppr_we) cppr_q <= cppr_val;
      irq_q <= (pipr_q < cppr_q);
    end
  end

  AST_EMPTY_PIPR: assert property (@(posedge clk) disable iff (rst)
    (ipb_q == '0) |-> (pipr_q == 8'hFF)); // R9
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    (cppr_q == 8'h00) |=> !irq_q); // R10
  AST_IPB_KEEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(ipb_q) & ~ipb_q) == '0)); // R6

endmodule

// File: rtl/irqbl_resend_top.sv
module irqbl_resend_top
  import irqbl_pkg::*;
#(
  parameter int BLK_W        = 2,
  parameter int IDX_W        = 3,
  parameter int NUM_BLK      = 2,
  parameter int RECS_PER_BLK = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ntf_valid,
  output logic             ntf_ready,
  input  logic [BLK_W-1:0] ntf_blk,
  input  logic [IDX_W-1:0] ntf_idx,
  input  logic [2:0]       ntf_prio,
  input  logic             ntf_backlog,
  input  logic             ntf_fmt1,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [31:0]      push_word,
  input  logic             cppr_we,
  input  logic [7:0]       cppr_val,
  output logic [31:0]      ctx_word,
  output logic [7:0]       pend_buf,
  output logic [7:0]       pend_prio,
  output logic             irq,
  output logic             err_cfg,
  output logic             err_id
);

  localparam int AW = BLK_W + IDX_W;

  seq_state_e       st_q;
  logic             idle, push_fire, ntf_fire;
  logic             op_push_q, vo_q, bl_q, f1_q;
  logic [BLK_W-1:0] blk_q;
  logic [IDX_W-1:0] idx_q;
  logic [2:0]       prio_q;
  logic             id_ok, need_tbl;
  logic             rd_en, wr_en, merge_en;
  logic [31:0]      rd_data, wr_data;
  logic [7:0]       fld, merge_bits;

  assign idle = (st_q == ST_IDLE);

  irqbl_arbiter i_arb (
    .clk(clk), .rst(rst), .idle(idle),
    .push_valid(push_valid), .ntf_valid(ntf_valid),
    .push_ready(push_ready), .ntf_ready(ntf_ready),
    .push_fire(push_fire), .ntf_fire(ntf_fire)
  );

  // request capture and three-step sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ctx_word  <= '0;
      op_push_q <= 1'b0;
      vo_q      <= 1'b0;
      bl_q      <= 1'b0;
      f1_q      <= 1'b0;
      blk_q     <= '0;
      idx_q     <= '0;
      prio_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (push_fire) begin
            ctx_word  <= push_word;
            op_push_q <= 1'b1;
            vo_q      <= push_word[CTX_VO_BIT];
            blk_q     <= push_word[AW-1:IDX_W];
            idx_q     <= push_word[IDX_W-1:0];
            bl_q      <= 1'b0;
            f1_q      <= 1'b0;
            st_q      <= ST_READ;
          end else if (ntf_fire) begin
            op_push_q <= 1'b0;
            vo_q      <= 1'b0;
            blk_q     <= ntf_blk;
            idx_q     <= ntf_idx;
            prio_q    <= ntf_prio;
            bl_q      <= ntf_backlog;
            f1_q      <= ntf_fmt1;
            st_q      <= ST_READ;
          end
        end
        ST_READ:  st_q <= ST_WRITE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign id_ok = ({1'b0, blk_q} < (BLK_W+1)'(NUM_BLK)) &&
                 ({1'b0, idx_q} < (IDX_W+1)'(RECS_PER_BLK));
  assign need_tbl = id_ok && (op_push_q ? vo_q : (bl_q && !f1_q));
  assign rd_en    = (st_q == ST_READ) && need_tbl;
  assign fld      = rd_data[FLD_HI:FLD_LO];

  always_comb begin
    wr_en      = 1'b0;
    wr_data    = rd_data;
    merge_en   = 1'b0;
    merge_bits = '0;
    if (st_q == ST_WRITE && need_tbl) begin
      if (op_push_q) begin
        if (fld != '0) begin
          wr_en      = 1'b1;
          wr_data    = {rd_data[31:FLD_HI+1], 8'h00, rd_data[FLD_LO-1:0]};
          merge_en   = 1'b1;
          merge_bits = fld;
        end
      end else begin
        wr_en   = 1'b1;
        wr_data = {rd_data[31:FLD_HI+1], fld | (8'h80 >> prio_q),
                   rd_data[FLD_LO-1:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_cfg <= 1'b0;
      err_id  <= 1'b0;
    end else begin
      err_cfg <= (st_q == ST_WRITE) && !op_push_q && bl_q && f1_q;
      err_id  <= (st_q == ST_WRITE) && !id_ok &&
                 (op_push_q ? vo_q : (bl_q && !f1_q));
    end
  end

  irqbl_rec_table #(.AW(AW), .DW(32)) i_tbl (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_addr({blk_q, idx_q}), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr({blk_q, idx_q}), .wr_data(wr_data)
  );

  irqbl_prio_ctx i_ctx (
    .clk(clk), .rst(rst),
    .merge_en(merge_en), .merge_bits(merge_bits),
    .cppr_we(cppr_we), .cppr_val(cppr_val),
    .ipb_q(pend_buf), .pipr_q(pend_prio), .irq_q(irq)
  );

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |-> (!push_ready && !ntf_ready)); // R11
  AST_CTX_STORED: assert property (@(posedge clk) disable iff (rst)
    push_fire |=> (ctx_word == $past(push_word))); // R5
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(err_cfg && err_id)); // R3
  AST_NO_MERGE_IDLE: assert property (@(posedge clk) disable iff (rst)
    idle |=> $stable(pend_buf)); // R6

endmodule

// File: tb/test_irqbl_resend_top.sv
`timescale 1ns/1ps
module test_irqbl_resend_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ntf_valid = 0, ntf_backlog = 0, ntf_fmt1 = 0;
  logic [1:0]  ntf_blk = '0;
  logic [2:0]  ntf_idx = '0, ntf_prio = '0;
  logic        push_valid = 0, cppr_we = 0;
  logic [31:0] push_word = '0;
  logic [7:0]  cppr_val = '0;
  logic        ntf_ready, push_ready, irq, err_cfg, err_id;
  logic [31:0] ctx_word;
  logic [7:0]  pend_buf, pend_prio;

  int total = 0, bad = 0, errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irqbl_resend_top i_irqbl_resend_top (
    .clk(clk), .rst(rst),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_blk(ntf_blk),
    .ntf_idx(ntf_idx), .ntf_prio(ntf_prio), .ntf_backlog(ntf_backlog),
    .ntf_fmt1(ntf_fmt1), .push_valid(push_valid), .push_ready(push_ready),
    .push_word(push_word), .cppr_we(cppr_we), .cppr_val(cppr_val),
    .ctx_word(ctx_word), .pend_buf(pend_buf), .pend_prio(pend_prio),
    .irq(irq), .err_cfg(err_cfg), .err_id(err_id)
  );

  always @(posedge clk) if (!rst && (err_cfg || err_id)) errs++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_notify(input logic [31:0] id, input logic [2:0] p,
                           input logic bl, input logic f1);
    ntf_blk = id[4:3]; ntf_idx = id[2:0]; ntf_prio = p;
    ntf_backlog = bl; ntf_fmt1 = f1; ntf_valid = 1'b1;
    while (!ntf_ready) @(negedge clk);
    @(posedge clk); #1 ntf_valid = 1'b0;
    settle();
  endtask

  task automatic do_push(input logic [31:0] w);
    push_word = w; push_valid = 1'b1;
    while (!push_ready) @(negedge clk);
    @(posedge clk); #1 push_valid = 1'b0;
    settle();
  endtask

  task automatic do_cppr(input logic [7:0] v);
    cppr_val = v; cppr_we = 1'b1;
    @(posedge clk); #1 cppr_we = 1'b0;
    settle();
  endtask

  typedef struct packed {
    logic [1:0]  op;   // 0 notify, 1 push, 2 priority load
    logic [31:0] word;
    logic [2:0]  prio;
    logic        bl;
    logic        f1;
    logic [7:0]  ipb;
    logic [7:0]  pipr;
    logic        irq;
    logic        err;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 32'h02, 3'd3, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0},  // R2
    '{2'd0, 32'h02, 3'd5, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0},  // R2
    '{2'd0, 32'h02, 3'd1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b1},  // R3
    '{2'd0, 32'h02, 3'd0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0},  // R4
    '{2'd1, 32'h00000002, 3'd0, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0},  // R7
    '{2'd1, 32'h80000002, 3'd0, 1'b0, 1'b0, 8'h14, 8'h03, 1'b0, 1'b0},  // R6
    '{2'd1, 32'h80000002, 3'd0, 1'b0, 1'b0, 8'h14, 8'h03, 1'b0, 1'b0},  // R6
    '{2'd0, 32'h0D, 3'd0, 1'b1, 1'b0, 8'h14, 8'h03, 1'b0, 1'b0},  // R2
    '{2'd1, 32'h80000010, 3'd0, 1'b0, 1'b0, 8'h14, 8'h03, 1'b0, 1'b1},  // R8
    '{2'd1, 32'h80000007, 3'd0, 1'b0, 1'b0, 8'h14, 8'h03, 1'b0, 1'b1},  // R8
    '{2'd0, 32'h0E, 3'd2, 1'b1, 1'b0, 8'h14, 8'h03, 1'b0, 1'b1},  // R8
    '{2'd1, 32'h8000000D, 3'd0, 1'b0, 1'b0, 8'h94, 8'h00, 1'b0, 1'b0},  // R9
    '{2'd2, 32'h04, 3'd0, 1'b0, 1'b0, 8'h94, 8'h00, 1'b1, 1'b0},  // R10
    '{2'd2, 32'h00, 3'd0, 1'b0, 1'b0, 8'h94, 8'h00, 1'b0, 1'b0}   // R10
  };

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 pend_buf", pend_buf, 8'h00);
    chk("R1 pend_prio", pend_prio, 8'hFF);
    chk("R1 ctx_word", ctx_word, 32'h0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 ready", {push_ready, ntf_ready}, 2'b11);

    for (int v = 0; v < NV; v++) begin
      int e0;
      e0 = errs;
      case (VEC[v].op)
        2'd0: do_notify(VEC[v].word, VEC[v].prio, VEC[v].bl, VEC[v].f1);
        2'd1: begin
          do_push(VEC[v].word);
          chk($sformatf("R5 vec%0d ctx_word", v), ctx_word, VEC[v].word);
        end
        default: do_cppr(VEC[v].word[7:0]);
      endcase
      chk($sformatf("R6 vec%0d pend_buf", v), pend_buf, VEC[v].ipb);
      chk($sformatf("R9 vec%0d pend_prio", v), pend_prio, VEC[v].pipr);
      chk($sformatf("R10 vec%0d irq", v), irq, VEC[v].irq);
      chk($sformatf("R8 vec%0d error pulses", v), errs - e0, VEC[v].err ? 1 : 0);
    end

    // R11: push and notify to the same record offered in one idle cycle
    do_reset();
    @(negedge clk);
    push_word = 32'h80000002; push_valid = 1'b1;
    ntf_blk = 2'd0; ntf_idx = 3'd2; ntf_prio = 3'd6;
    ntf_backlog = 1'b1; ntf_fmt1 = 1'b0; ntf_valid = 1'b1;
    #1;
    chk("R11 push ready on contention", push_ready, 1'b1);
    chk("R11 notify held on contention", ntf_ready, 1'b0);
    @(posedge clk); #1 push_valid = 1'b0;
    chk("R11 ready low while busy", {push_ready, ntf_ready}, 2'b00);
    @(negedge clk);
    chk("R11 ready low second busy cycle", {push_ready, ntf_ready}, 2'b00);
    while (!ntf_ready) @(negedge clk);
    chk("R11 push found nothing", pend_buf, 8'h00);
    @(posedge clk); #1 ntf_valid = 1'b0;
    settle();
    chk("R2 notify parked after push", pend_buf, 8'h00);
    do_push(32'h80000002);
    chk("R6 parked bit replayed", pend_buf, 8'h02);
    chk("R9 prio of bit 6", pend_prio, 8'h06);
    do_cppr(8'h06);
    chk("R10 equal priority no irq", irq, 1'b0);
    do_cppr(8'h07);
    chk("R10 lower value raises irq", irq, 1'b1);

    // R9/R10: empty buffer never requests, even with the loosest priority
    do_reset();
    do_cppr(8'hFF);
    chk("R10 empty buffer no irq", irq, 1'b0);
    chk("R9 empty prio", pend_prio, 8'hFF);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule